// File: doc/BRIEF.md
# Burst Byte-Memory Slave with Error Responses

This block is an AXI4 subordinate that holds a small byte-addressed memory. Each byte has a flag that records whether it has ever been written. The write side (AW, W, B) and the read side (AR, R) are separate controllers that run at the same time. Each controller handles one burst at a time and takes no new address until its current burst has fully finished.

Beat bytes sit little-endian, one per address. They are packed at the bottom of the data bus, and the slot position is taken modulo the beat size rather than from the true lane position. The same address and slot generator serves both sides.

Three cases give an error response:
- a write byte that falls outside the memory;
- a WRAP write whose start address is not aligned to the beat size;
- a read beat that touches a byte never written.

A short reset synchronizer inside the block releases the asynchronous active-low reset in step with the clock.

Top module: `axbm_slave`

## Requirements
- R1: While reset is applied, b_valid and r_valid are low. Once reset has been released, aw_ready and ar_ready are high and w_ready is low.
- R2: aw_ready is high only when no write burst is in progress. It stays low from the AW handshake until the B handshake. w_ready is low until an AW handshake has taken place, and a W beat is consumed only when w_valid and w_ready are both high.
- R3: For a beat at address A with N = 2^size bytes per beat, let off = A mod N. The beat carries N-off bytes. Byte k goes to address A+k and is taken from data-bus byte slot (off+k) mod N, meaning bits 8*slot+7 down to 8*slot.
- R4: The burst encoding is 2'b00 FIXED, 2'b01 INCR and 2'b10 WRAP. A FIXED burst repeats the start address on every beat. Otherwise the next beat address is floor(A/N)*N + N.
- R5: A WRAP burst has a length of 2, 4, 8 or 16 beats. Its window is the block of N*(len+1) bytes that holds the start address, and the beat address returns to the bottom of that window on reaching its top.
- R6: A write byte at an address at or beyond the memory size is not stored, and the burst's response is 2'b01. In-range bytes of the same burst are still stored.
- R7: A WRAP write whose start address is not a multiple of N stores no byte and responds 2'b01.
- R8: After the handshake on the last W beat, b_id (equal to the burst's aw_id) and b_resp (2'b01 on error, 2'b00 otherwise) are set. b_valid rises one cycle later and stays high with a stable b_id and b_resp until b_ready is seen. At that point it falls and aw_ready returns high.
- R9: Read data places bytes in the same slots as R3, and unused slots read 0. A byte that was never written, or that lies outside the memory, reads 0x00 and makes r_resp 2'b01 for that beat only. Otherwise r_resp is 2'b00.
- R10: r_id equals the burst's ar_id. r_last is high only on the beat whose index equals ar_len. r_valid holds with stable r_data, r_resp, r_last and r_id until r_ready, then drops for one cycle before the next beat.
- R11: Write and read bursts progress at the same time without waiting on each other. ar_ready stays low from the AR handshake until the last R handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_id | input | ID_W | Write burst ID |
| aw_addr | input | A_WIDTH | Write start address |
| aw_len | input | 8 | Write beats minus one |
| aw_size | input | 3 | log2 of bytes per write beat |
| aw_burst | input | 2 | Write burst type |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | D_WIDTH | Write data, bytes packed from bit 0 |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_id | input | ID_W | Read burst ID |
| ar_addr | input | A_WIDTH | Read start address |
| ar_len | input | 8 | Read beats minus one |
| ar_size | input | 3 | log2 of bytes per read beat |
| ar_burst | input | 2 | Read burst type |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | ID_W | Read data ID |
| r_data | output | D_WIDTH | Read data, bytes packed from bit 0 |
| r_resp | output | 2 | Read response code |
| r_last | output | 1 | Last read beat |

## Verification
The assertions assume that the manager keeps each beat size at or below the bus width and never uses the reserved burst code 2'b11. They also assume that WRAP lengths are 2, 4, 8 or 16 beats, and that b_ready and r_ready are driven to known values. The stimulus respects these limits: sizes are drawn from byte, half-word and word only, types are drawn from the three legal codes only, and WRAP lengths are drawn from the legal set only. Beyond those limits, the random addresses may be unaligned and may run past the top of memory, and valid and ready are randomly delayed so that the hold rules are exercised.

// File: rtl/axbm_pkg.sv
package axbm_pkg;
  localparam logic [1:0] BT_FIXED = 2'b00;
  localparam logic [1:0] BT_INCR  = 2'b01;
  localparam logic [1:0] BT_WRAP  = 2'b10;
  localparam logic [1:0] RSP_OKAY = 2'b00;
  localparam logic [1:0] RSP_ERR  = 2'b01;
endpackage

// File: rtl/axbm_lane_gen.sv
module axbm_lane_gen #(
  parameter int DBYTES = 4,
  parameter int EXT_W  = 19,
  parameter int LANE_W = 2
) (
  input  logic [EXT_W-1:0]                cur_addr,
  input  logic [2:0]                      beat_size,
  input  logic [1:0]                      burst,
  input  logic [EXT_W-1:0]                wrap_lo,
  input  logic [EXT_W-1:0]                wrap_hi,
  output logic [DBYTES-1:0]               lane_act,
  output logic [DBYTES-1:0][EXT_W-1:0]    lane_addr,
  output logic [DBYTES-1:0][LANE_W-1:0]   lane_slot,
  output logic [EXT_W-1:0]                next_addr
);
  import axbm_pkg::*;

  logic [EXT_W-1:0] nb, nb_mask, off, span, step;

  always_comb begin
    nb      = EXT_W'(1) << beat_size;
    nb_mask = nb - EXT_W'(1);
    off     = cur_addr & nb_mask;
    span    = nb - off;
    step    = (cur_addr & ~nb_mask) + nb;
    if (burst == BT_FIXED)
      next_addr = cur_addr;
    else if (burst == BT_WRAP && step >= wrap_hi)
      next_addr = wrap_lo;
    else
      next_addr = step;
  end

  for (genvar k = 0; k < DBYTES; k++) begin : g_lane
    assign lane_act[k]  = EXT_W'(k) < span;
    assign lane_addr[k] = cur_addr + EXT_W'(k);
    assign lane_slot[k] = LANE_W'((off + EXT_W'(k)) & nb_mask);
  end
endmodule

// File: rtl/axbm_store.sv
module axbm_store #(
  parameter int MEM_BYTES = 256,
  parameter int DBYTES    = 4,
  parameter int EXT_W     = 19
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DBYTES-1:0]             wr_en,
  input  logic [DBYTES-1:0][EXT_W-1:0]  wr_addr,
  input  logic [DBYTES-1:0][7:0]        wr_byte,
  input  logic [DBYTES-1:0][EXT_W-1:0]  rd_addr,
  output logic [DBYTES-1:0][7:0]        rd_byte,
  output logic [DBYTES-1:0]             rd_ok
);
  localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

  logic [7:0]           cells [MEM_BYTES];
  logic [MEM_BYTES-1:0] filled;
  logic [DBYTES-1:0]    wr_hit;

  for (genvar k = 0; k < DBYTES; k++) begin : g_port
    assign wr_hit[k]  = wr_en[k] && (wr_addr[k] < EXT_W'(MEM_BYTES));
    assign rd_byte[k] = cells[rd_addr[k][IDX_W-1:0]];
    assign rd_ok[k]   = (rd_addr[k] < EXT_W'(MEM_BYTES)) && filled[rd_addr[k][IDX_W-1:0]];

    // R6
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |-> (wr_addr[k] < EXT_W'(MEM_BYTES)));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DBYTES; k++)
      if (wr_hit[k]) cells[wr_addr[k][IDX_W-1:0]] <= wr_byte[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filled <= '0;
    else
      for (int k = 0; k < DBYTES; k++)
        if (wr_hit[k]) filled[wr_addr[k][IDX_W-1:0]] <= 1'b1;
  end
endmodule

// File: rtl/axbm_wr_path.sv
module axbm_wr_path #(
  parameter int ID_W      = 4,
  parameter int A_WIDTH   = 8,
  parameter int D_WIDTH   = 32,
  parameter int MEM_BYTES = 256,
  parameter int DBYTES    = 4,
  parameter int EXT_W     = 19,
  parameter int LANE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          aw_valid,
  output logic                          aw_ready,
  input  logic [ID_W-1:0]               aw_id,
  input  logic [A_WIDTH-1:0]            aw_addr,
  input  logic [7:0]                    aw_len,
  input  logic [2:0]                    aw_size,
  input  logic [1:0]                    aw_burst,
  input  logic                          w_valid,
  output logic                          w_ready,
  input  logic [D_WIDTH-1:0]            w_data,
  output logic                          b_valid,
  input  logic                          b_ready,
  output logic [ID_W-1:0]               b_id,
  output logic [1:0]                    b_resp,
  output logic [DBYTES-1:0]             mem_we,
  output logic [DBYTES-1:0][EXT_W-1:0]  mem_addr,
  output logic [DBYTES-1:0][7:0]        mem_byte
);
  import axbm_pkg::*;

  typedef enum logic [1:0] {WS_IDLE, WS_DATA, WS_GAP, WS_RESP} wst_e;

  wst_e             st_q, st_d;
  logic [ID_W-1:0]  id_q;
  logic [2:0]       size_q;
  logic [1:0]       burst_q;
  logic [7:0]       len_q, cnt_q;
  logic [EXT_W-1:0] addr_q, lo_q, hi_q;
  logic             skip_q, err_q;
  logic [ID_W-1:0]  bid_q;
  logic [1:0]       bresp_q;

  logic             aw_fire, w_fire, b_fire, last_beat, beat_err, aw_mis;
  logic [EXT_W-1:0] aw_start, aw_mask, aw_total, aw_lo;
  logic [DBYTES-1:0]              lane_act, lane_oor;
  logic [DBYTES-1:0][EXT_W-1:0]   lane_addr;
  logic [DBYTES-1:0][LANE_W-1:0]  lane_slot;
  logic [EXT_W-1:0]               next_addr;

  axbm_lane_gen #(.DBYTES(DBYTES), .EXT_W(EXT_W), .LANE_W(LANE_W)) i_lanes (
    .cur_addr(addr_q), .beat_size(size_q), .burst(burst_q),
    .wrap_lo(lo_q), .wrap_hi(hi_q),
    .lane_act(lane_act), .lane_addr(lane_addr), .lane_slot(lane_slot),
    .next_addr(next_addr)
  );

  always_comb begin
    aw_fire   = (st_q == WS_IDLE) && aw_valid;
    w_fire    = (st_q == WS_DATA) && w_valid;
    b_fire    = (st_q == WS_RESP) && b_ready;
    last_beat = (cnt_q == len_q);
    aw_start  = EXT_W'(aw_addr);
    aw_mask   = (EXT_W'(1) << aw_size) - EXT_W'(1);
    aw_total  = (EXT_W'(aw_len) + EXT_W'(1)) << aw_size;
    aw_lo     = aw_start & ~(aw_total - EXT_W'(1));
    aw_mis    = (aw_burst == BT_WRAP) && ((aw_start & aw_mask) != '0);
  end

  for (genvar k = 0; k < DBYTES; k++) begin : g_wlane
    assign lane_oor[k] = lane_addr[k] >= EXT_W'(MEM_BYTES);
    assign mem_we[k]   = w_fire && lane_act[k] && !lane_oor[k] && !skip_q;
    assign mem_addr[k] = lane_addr[k];
    assign mem_byte[k] = w_data[8*lane_slot[k] +: 8];
  end
  assign beat_err = |(lane_act & lane_oor);

  always_comb begin
    st_d = st_q;
    case (st_q)
      WS_IDLE: if (aw_fire) st_d = WS_DATA;
      WS_DATA: if (w_fire && last_beat) st_d = WS_GAP;
      WS_GAP:  st_d = WS_RESP;
      WS_RESP: if (b_fire) st_d = WS_IDLE;
      default: st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0; size_q <= '0; burst_q <= '0; len_q <= '0;
      lo_q <= '0; hi_q <= '0; skip_q <= 1'b0;
    end else if (aw_fire) begin
      id_q <= aw_id; size_q <= aw_size; burst_q <= aw_burst; len_q <= aw_len;
      lo_q <= aw_lo; hi_q <= aw_lo + aw_total; skip_q <= aw_mis;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; cnt_q <= '0; err_q <= 1'b0;
    end else if (aw_fire) begin
      addr_q <= aw_start; cnt_q <= '0; err_q <= 1'b0;
    end else if (w_fire) begin
      addr_q <= next_addr; cnt_q <= cnt_q + 8'd1; err_q <= err_q | beat_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bid_q <= '0; bresp_q <= RSP_OKAY;
    end else if (w_fire && last_beat) begin
      bid_q   <= id_q;
      bresp_q <= (err_q || beat_err || skip_q) ? RSP_ERR : RSP_OKAY;
    end
  end

  assign aw_ready = (st_q == WS_IDLE);
  assign w_ready  = (st_q == WS_DATA);
  assign b_valid  = (st_q == WS_RESP);
  assign b_id     = bid_q;
  assign b_resp   = bresp_q;

  // R2
  aw_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ready || b_valid) |-> !aw_ready);
  // R8
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid && !b_ready |=> b_valid && $stable(b_id) && $stable(b_resp));
  // R8
  b_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> !$past(w_ready) && $past(w_ready && w_valid, 2));
endmodule

// File: rtl/axbm_rd_path.sv
module axbm_rd_path #(
  parameter int ID_W    = 4,
  parameter int A_WIDTH = 8,
  parameter int D_WIDTH = 32,
  parameter int DBYTES  = 4,
  parameter int EXT_W   = 19,
  parameter int LANE_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ar_valid,
  output logic                          ar_ready,
  input  logic [ID_W-1:0]               ar_id,
  input  logic [A_WIDTH-1:0]            ar_addr,
  input  logic [7:0]                    ar_len,
  input  logic [2:0]                    ar_size,
  input  logic [1:0]                    ar_burst,
  output logic                          r_valid,
  input  logic                          r_ready,
  output logic [ID_W-1:0]               r_id,
  output logic [D_WIDTH-1:0]            r_data,
  output logic [1:0]                    r_resp,
  output logic                          r_last,
  output logic [DBYTES-1:0][EXT_W-1:0]  mem_addr,
  input  logic [DBYTES-1:0][7:0]        mem_byte,
  input  logic [DBYTES-1:0]             mem_ok
);
  import axbm_pkg::*;

  typedef enum logic [1:0] {RS_IDLE, RS_LOAD, RS_SEND} rst_e;

  rst_e             st_q, st_d;
  logic [ID_W-1:0]  id_q;
  logic [2:0]       size_q;
  logic [1:0]       burst_q;
  logic [7:0]       len_q, cnt_q;
  logic [EXT_W-1:0] addr_q, lo_q, hi_q;
  logic [D_WIDTH-1:0] data_q, data_d;
  logic [1:0]       resp_q;
  logic             last_q, beat_err;

  logic             ar_fire, load_en, r_fire;
  logic [EXT_W-1:0] ar_start, ar_total, ar_lo;
  logic [DBYTES-1:0]              lane_act;
  logic [DBYTES-1:0][LANE_W-1:0]  lane_slot;
  logic [EXT_W-1:0]               next_addr;

  axbm_lane_gen #(.DBYTES(DBYTES), .EXT_W(EXT_W), .LANE_W(LANE_W)) i_lanes (
    .cur_addr(addr_q), .beat_size(size_q), .burst(burst_q),
    .wrap_lo(lo_q), .wrap_hi(hi_q),
    .lane_act(lane_act), .lane_addr(mem_addr), .lane_slot(lane_slot),
    .next_addr(next_addr)
  );

  always_comb begin
    ar_fire  = (st_q == RS_IDLE) && ar_valid;
    load_en  = (st_q == RS_LOAD);
    r_fire   = (st_q == RS_SEND) && r_ready;
    ar_start = EXT_W'(ar_addr);
    ar_total = (EXT_W'(ar_len) + EXT_W'(1)) << ar_size;
    ar_lo    = ar_start & ~(ar_total - EXT_W'(1));
  end

  always_comb begin
    data_d   = '0;
    beat_err = 1'b0;
    for (int k = 0; k < DBYTES; k++) begin
      if (lane_act[k]) begin
        if (mem_ok[k]) data_d[8*lane_slot[k] +: 8] = mem_byte[k];
        else           beat_err = 1'b1;
      end
    end
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      RS_IDLE: if (ar_fire) st_d = RS_LOAD;
      RS_LOAD: st_d = RS_SEND;
      RS_SEND: if (r_fire) st_d = last_q ? RS_IDLE : RS_LOAD;
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0; size_q <= '0; burst_q <= '0; len_q <= '0; lo_q <= '0; hi_q <= '0;
    end else if (ar_fire) begin
      id_q <= ar_id; size_q <= ar_size; burst_q <= ar_burst; len_q <= ar_len;
      lo_q <= ar_lo; hi_q <= ar_lo + ar_total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; cnt_q <= '0;
    end else if (ar_fire) begin
      addr_q <= ar_start; cnt_q <= '0;
    end else if (load_en) begin
      addr_q <= next_addr; cnt_q <= cnt_q + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; resp_q <= RSP_OKAY; last_q <= 1'b0;
    end else if (load_en) begin
      data_q <= data_d;
      resp_q <= beat_err ? RSP_ERR : RSP_OKAY;
      last_q <= (cnt_q == len_q);
    end
  end

  assign ar_ready = (st_q == RS_IDLE);
  assign r_valid  = (st_q == RS_SEND);
  assign r_id     = id_q;
  assign r_data   = data_q;
  assign r_resp   = resp_q;
  assign r_last   = last_q;

  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_resp)
                            && $stable(r_last) && $stable(r_id));
  // R10
  r_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_ready |=> !r_valid);
  // R11
  ar_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready);
  // R10
  r_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid && r_ready && r_last |=> ar_ready);
endmodule

// File: rtl/axbm_slave.sv
module axbm_slave #(
  parameter int ID_W      = 4,
  parameter int A_WIDTH   = 8,
  parameter int D_WIDTH   = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               aw_valid,
  output logic               aw_ready,
  input  logic [ID_W-1:0]    aw_id,
  input  logic [A_WIDTH-1:0] aw_addr,
  input  logic [7:0]         aw_len,
  input  logic [2:0]         aw_size,
  input  logic [1:0]         aw_burst,
  input  logic               w_valid,
  output logic               w_ready,
  input  logic [D_WIDTH-1:0] w_data,
  output logic               b_valid,
  input  logic               b_ready,
  output logic [ID_W-1:0]    b_id,
  output logic [1:0]         b_resp,
  input  logic               ar_valid,
  output logic               ar_ready,
  input  logic [ID_W-1:0]    ar_id,
  input  logic [A_WIDTH-1:0] ar_addr,
  input  logic [7:0]         ar_len,
  input  logic [2:0]         ar_size,
  input  logic [1:0]         ar_burst,
  output logic               r_valid,
  input  logic               r_ready,
  output logic [ID_W-1:0]    r_id,
  output logic [D_WIDTH-1:0] r_data,
  output logic [1:0]         r_resp,
  output logic               r_last
);
  localparam int DBYTES = D_WIDTH / 8;
  localparam int LANE_W = (DBYTES > 1) ? $clog2(DBYTES) : 1;
  localparam int EXT_W  = A_WIDTH + 9 + $clog2(DBYTES);

  logic [1:0] rst_sync;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  logic [DBYTES-1:0]             m_we, m_ok;
  logic [DBYTES-1:0][EXT_W-1:0]  m_waddr, m_raddr;
  logic [DBYTES-1:0][7:0]        m_wbyte, m_rbyte;

  axbm_wr_path #(.ID_W(ID_W), .A_WIDTH(A_WIDTH), .D_WIDTH(D_WIDTH), .MEM_BYTES(MEM_BYTES),
                 .DBYTES(DBYTES), .EXT_W(EXT_W), .LANE_W(LANE_W)) i_wr (
    .clk(clk), .rst_n(core_rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .mem_we(m_we), .mem_addr(m_waddr), .mem_byte(m_wbyte)
  );

  axbm_rd_path #(.ID_W(ID_W), .A_WIDTH(A_WIDTH), .D_WIDTH(D_WIDTH),
                 .DBYTES(DBYTES), .EXT_W(EXT_W), .LANE_W(LANE_W)) i_rd (
    .clk(clk), .rst_n(core_rst_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last),
    .mem_addr(m_raddr), .mem_byte(m_rbyte), .mem_ok(m_ok)
  );

  axbm_store #(.MEM_BYTES(MEM_BYTES), .DBYTES(DBYTES), .EXT_W(EXT_W)) i_store (
    .clk(clk), .rst_n(core_rst_n),
    .wr_en(m_we), .wr_addr(m_waddr), .wr_byte(m_wbyte),
    .rd_addr(m_raddr), .rd_byte(m_rbyte), .rd_ok(m_ok)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk) !core_rst_n |-> !b_valid && !r_valid);
endmodule

// File: tb/test_axbm_slave.sv
`timescale 1ns/1ps
module test_axbm_slave;
  logic clk = 1'b0;
  logic rst_n;
  logic aw_valid, aw_ready, w_valid, w_ready, b_valid, b_ready;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic [3:0] aw_id, b_id, ar_id, r_id;
  logic [7:0] aw_addr, aw_len, ar_addr, ar_len;
  logic [2:0] aw_size, ar_size;
  logic [1:0] aw_burst, ar_burst, b_resp, r_resp;
  logic [31:0] w_data, r_data;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] mem_m [256];
  bit         vld_m [256];

  always #4 clk = ~clk;

  axbm_slave i_axbm_slave (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int wrap_low(int a, int nb, int len);
    return (a / (nb * (len + 1))) * (nb * (len + 1));
  endfunction

  function automatic int step_addr(int a, int nb, int bt, int lo, int hi);
    int n;
    if (bt == 0) return a;
    n = (a / nb) * nb + nb;
    if (bt == 2 && n >= hi) n = lo;
    return n;
  endfunction

  task automatic axi_write(input logic [3:0] id, input int addr, input int len,
                           input int size, input int bt, input string req);
    int nb, a, lo, hi, off;
    bit mis, err, ok;
    logic [31:0] d;
    nb = 1 << size; a = addr;
    lo = wrap_low(addr, nb, len); hi = lo + nb * (len + 1);
    mis = (bt == 2) && (addr % nb != 0);
    err = mis;
    @(negedge clk);
    check(w_ready == 1'b0, "R2", "w_ready before AW", w_ready, 0);
    aw_valid = 1; aw_id = id; aw_addr = addr[7:0]; aw_len = len[7:0];
    aw_size = size[2:0]; aw_burst = bt[1:0];
    forever begin ok = aw_ready; @(negedge clk); if (ok) break; end
    aw_valid = 0;
    for (int b = 0; b <= len; b++) begin
      repeat ($urandom % 3) @(negedge clk);
      if (b == 0) check(aw_ready == 1'b0, "R2", "aw_ready mid-burst", aw_ready, 0);
      d = $urandom;
      w_valid = 1; w_data = d;
      forever begin ok = w_ready; @(negedge clk); if (ok) break; end
      w_valid = 0;
      off = a % nb;
      for (int k = 0; k < nb - off; k++) begin
        if (a + k >= 256) err = 1;
        else if (!mis) begin
          mem_m[a + k] = d[8 * ((off + k) % nb) +: 8];
          vld_m[a + k] = 1;
        end
      end
      a = step_addr(a, nb, bt, lo, hi);
    end
    check(b_valid == 1'b0, "R8", "b_valid one cycle after last beat", b_valid, 0);
    @(negedge clk);
    check(b_valid == 1'b1, "R8", "b_valid rise", b_valid, 1);
    check(b_id == id, "R8", "b_id", b_id, id);
    check(b_resp == (err ? 2'b01 : 2'b00), req, "b_resp", b_resp, err ? 1 : 0);
    repeat ($urandom % 3) @(negedge clk);
    check(b_valid == 1'b1, "R8", "b_valid held", b_valid, 1);
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
    check(b_valid == 1'b0 && aw_ready == 1'b1, "R8", "b done, aw_ready back",
          {b_valid, aw_ready}, 2'b01);
  endtask

  task automatic axi_read(input logic [3:0] id, input int addr, input int len,
                          input int size, input int bt, input string req);
    int nb, a, lo, hi, off;
    bit ok, eerr;
    logic [31:0] ed;
    nb = 1 << size; a = addr;
    lo = wrap_low(addr, nb, len); hi = lo + nb * (len + 1);
    @(negedge clk);
    ar_valid = 1; ar_id = id; ar_addr = addr[7:0]; ar_len = len[7:0];
    ar_size = size[2:0]; ar_burst = bt[1:0];
    forever begin ok = ar_ready; @(negedge clk); if (ok) break; end
    ar_valid = 0;
    for (int b = 0; b <= len; b++) begin
      ed = '0; eerr = 0; off = a % nb;
      for (int k = 0; k < nb - off; k++) begin
        if (a + k < 256 && vld_m[a + k]) ed[8 * ((off + k) % nb) +: 8] = mem_m[a + k];
        else eerr = 1;
      end
      a = step_addr(a, nb, bt, lo, hi);
      while (!r_valid) @(negedge clk);
      check(r_data == ed, req, "r_data", r_data, ed);
      check(r_resp == (eerr ? 2'b01 : 2'b00), "R9", "r_resp", r_resp, eerr ? 1 : 0);
      check(r_last == (b == len), "R10", "r_last", r_last, (b == len) ? 1 : 0);
      check(r_id == id, "R10", "r_id", r_id, id);
      check(ar_ready == 1'b0, "R11", "ar_ready mid-burst", ar_ready, 0);
      repeat ($urandom % 3) @(negedge clk);
      check(r_valid && r_data == ed, "R10", "r beat held", r_data, ed);
      r_ready = 1;
      @(negedge clk);
      r_ready = 0;
      check(r_valid == 1'b0, "R10", "r_valid gap", r_valid, 0);
    end
    check(ar_ready == 1'b1, "R11", "ar_ready after burst", ar_ready, 1);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 256; i++) begin vld_m[i] = 0; mem_m[i] = 8'h00; end
    rst_n = 0; aw_valid = 0; w_valid = 0; b_ready = 0; ar_valid = 0; r_ready = 0;
    aw_id = 0; aw_addr = 0; aw_len = 0; aw_size = 0; aw_burst = 0; w_data = 0;
    ar_id = 0; ar_addr = 0; ar_len = 0; ar_size = 0; ar_burst = 0;
    repeat (3) @(negedge clk);
    check(b_valid == 1'b0 && r_valid == 1'b0, "R1", "valids in reset", {b_valid, r_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(aw_ready && ar_ready && !w_ready && !b_valid && !r_valid, "R1", "post-reset",
          {aw_ready, ar_ready, w_ready, b_valid, r_valid}, 5'b11000);

    axi_read (4'h3, 8'h80, 1, 2, 1, "R9");         // never written
    axi_write(4'h5, 8'h11, 2, 2, 1, "R3");         // unaligned INCR word
    axi_read (4'h6, 8'h10, 2, 2, 1, "R3");
    axi_write(4'h7, 8'h20, 3, 1, 0, "R4");         // FIXED half-word
    axi_read (4'h8, 8'h20, 3, 0, 1, "R4");
    axi_write(4'h9, 8'h38, 3, 2, 2, "R5");         // aligned WRAP
    axi_read (4'ha, 8'h30, 3, 2, 1, "R5");
    axi_read (4'hb, 8'h34, 3, 2, 2, "R5");
    axi_write(4'hc, 8'h42, 3, 2, 2, "R7");         // misaligned WRAP
    axi_read (4'hd, 8'h40, 3, 2, 1, "R7");
    axi_write(4'he, 8'hf8, 3, 2, 1, "R6");         // runs past memory top
    axi_read (4'hf, 8'hf8, 1, 2, 1, "R6");
    axi_write(4'h1, 8'h64, 0, 2, 1, "R9");
    axi_read (4'h2, 8'h60, 1, 2, 1, "R9");         // error beat then good beat
    fork
      axi_write(4'h4, 8'ha0, 7, 2, 1, "R11");
      axi_read (4'h5, 8'h10, 3, 1, 1, "R11");
    join
    axi_read (4'h6, 8'ha0, 7, 2, 1, "R11");

    for (int it = 0; it < 60; it++) begin
      int size, bt, len, addr;
      size = $urandom % 3; bt = $urandom % 3;
      if (bt == 2) len = (2 << ($urandom % 4)) - 1;
      else         len = $urandom % 8;
      addr = $urandom % 256;
      if (bt == 2 && ($urandom % 4 != 0)) addr = addr & ~((1 << size) - 1);
      axi_write(4'($urandom), addr, len, size, bt, "R3");
      axi_read (4'($urandom), addr, len, size, bt, "R4");
    end
    done = 1;
    finish_run();
  end
endmodule